// File: doc/BRIEF.md
# Ghost-Rejecting Key Change Reporter

This block sits between a keyboard matrix scanner and the logic that turns scancodes into key codes. Each time the scanner has a fresh picture of the pressed keys, it offers a snapshot of up to eight entry slots. Each slot carries a pressed flag, a row and a column. The block forms an 8-bit scancode for every pressed key. It can swallow a designated function key and move every other key into a second scancode layer. It throws away snapshots whose pressed keys form a ghosting pattern.

For every snapshot it keeps, the block compares the new key set with the last set it kept. It first emits a release event for each key that has gone, and then a press event for each key that is present now. The events leave on a valid/ready stream. A single-cycle sync pulse closes each kept snapshot. A new snapshot is taken only while the event side is idle.

Top module: `key_change_reporter`

## Requirements
- R1: Slot k occupies `snap_entries[8k+7:8k]`. Bit 7 is the pressed flag, bits 6:3 are the row and bits 2:0 are the column. The layer-0 scancode of a pressed key is row*8 + column.
- R2: A slot whose pressed flag is 0 produces no event and takes no part in the set comparison or the ghost check, whatever its row and column bits hold.
- R3: While `fn_layer_en` is 1 and some pressed slot's 7-bit row/column code equals `fn_code`, that key produces no event. Every other pressed key in that snapshot gets 128 added to its scancode.
- R4: While `ghost_en` is 1, at least three non-function keys are pressed, some pair of them shares a row and some pair shares a column, the snapshot is dropped. A dropped snapshot emits no event and no sync pulse, and it leaves the stored key set unchanged.
- R5: For a kept snapshot, each stored key whose scancode is absent from the new set gives one release event (`ev_press`=0). Releases follow stored slot order, and all of them come before any press.
- R6: For a kept snapshot, each of its keys gives one press event (`ev_press`=1) in ascending slot order. The new set then becomes the stored set.
- R7: A kept snapshot with no pressed key releases every stored key and leaves the stored set empty.
- R8: `ev_sync` is high for exactly one cycle after the last event of a kept snapshot has been accepted. `ev_valid` is low in that cycle.
- R9: `snap_ready` is low from the cycle after a snapshot is kept until the sync pulse. It stays high after a dropped snapshot.
- R10: While `ev_valid` is 1 and `ev_ready` is 0, the event payload holds unchanged in the next cycle.
- R11: After reset, `snap_ready` is 1, `ev_valid` and `ev_sync` are 0, and the stored key set is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| snap_valid | input | 1 | Snapshot offered |
| snap_ready | output | 1 | Block idle, snapshot can be taken |
| snap_entries | input | 64 | Eight entry slots, 8 bits each |
| fn_layer_en | input | 1 | Enables function-key layer handling |
| ghost_en | input | 1 | Enables ghost rejection |
| fn_code | input | 7 | Row/column code of the function key |
| ev_valid | output | 1 | Event available |
| ev_ready | input | 1 | Event consumer ready |
| ev_press | output | 1 | 1 = press, 0 = release |
| ev_code | output | 8 | Scancode of the event |
| ev_sync | output | 1 | One-cycle end-of-snapshot pulse |

## Verification
A snapshot is taken on the edge where `snap_valid` and `snap_ready` are both high. From the next edge on, the block visits one slot per edge on which the output register is free: eight release slots, then eight press slots, then the sync step. With `ev_ready` held high, `ev_sync` therefore appears 17 edges after the taking edge. Under back-pressure the sequence stretches by one edge per stalled cycle. For that reason the bench does not use fixed delays. It samples on falling edges and records an event whenever `ev_valid` is seen together with the `ev_ready` value it drove for the coming rising edge. It waits for the sync pulse before it compares the recorded list. For a dropped snapshot it watches 20 cycles for any event, pulse or loss of `snap_ready`.

// File: rtl/kcr_pkg.sv
package kcr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REL,
    ST_PRS,
    ST_END
  } kcr_state_e;

  localparam logic KIND_RELEASE = 1'b0;
  localparam logic KIND_PRESS   = 1'b1;
endpackage

// File: rtl/kcr_decode.sv
module kcr_decode #(
  parameter int SLOTS = 8,
  parameter int ROW_W = 4,
  parameter int COL_W = 3,
  localparam int RAW_W   = ROW_W + COL_W,
  localparam int ENTRY_W = RAW_W + 1,
  localparam int SC_W    = RAW_W + 1
) (
  input  logic [SLOTS*ENTRY_W-1:0] entries,
  input  logic                     fn_layer_en,
  input  logic                     ghost_en,
  input  logic [RAW_W-1:0]         fn_code,
  output logic [SLOTS-1:0]         key_vld,
  output logic [SC_W-1:0]          key_code [SLOTS],
  output logic                     ghost
);
  localparam int CNT_W = $clog2(SLOTS + 1);

  logic [RAW_W-1:0] raw [SLOTS];
  logic [SLOTS-1:0] pressed;
  logic [SLOTS-1:0] is_fn;
  logic             fn_hit;

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    assign raw[k]     = entries[k*ENTRY_W +: RAW_W];
    assign pressed[k] = entries[k*ENTRY_W + RAW_W];
    assign is_fn[k]   = pressed[k] && fn_layer_en && (raw[k] == fn_code);
    assign key_vld[k] = pressed[k] && !is_fn[k];
    assign key_code[k] = {fn_hit, raw[k]};
  end

  assign fn_hit = |is_fn;

  logic             row_pair;
  logic             col_pair;
  logic [CNT_W-1:0] n_keys;

  always_comb begin
    row_pair = 1'b0;
    col_pair = 1'b0;
    n_keys   = '0;
    for (int i = 0; i < SLOTS; i++) begin
      n_keys = n_keys + CNT_W'(key_vld[i]);
      for (int j = i + 1; j < SLOTS; j++) begin
        if (key_vld[i] && key_vld[j]) begin
          if (raw[i][RAW_W-1:COL_W] == raw[j][RAW_W-1:COL_W]) row_pair = 1'b1;
          if (raw[i][COL_W-1:0] == raw[j][COL_W-1:0]) col_pair = 1'b1;
        end
      end
    end
  end

  assign ghost = ghost_en && (n_keys >= CNT_W'(3)) && row_pair && col_pair;
endmodule

// File: rtl/kcr_set_diff.sv
module kcr_set_diff #(
  parameter int SLOTS = 8,
  parameter int SC_W  = 8
) (
  input  logic [SLOTS-1:0] old_vld,
  input  logic [SC_W-1:0]  old_code [SLOTS],
  input  logic [SLOTS-1:0] new_vld,
  input  logic [SC_W-1:0]  new_code [SLOTS],
  output logic [SLOTS-1:0] gone
);
  for (genvar j = 0; j < SLOTS; j++) begin : g_old
    logic still_there;
    always_comb begin
      still_there = 1'b0;
      for (int k = 0; k < SLOTS; k++) begin
        if (new_vld[k] && (new_code[k] == old_code[j])) still_there = 1'b1;
      end
    end
    assign gone[j] = old_vld[j] && !still_there;
  end
endmodule

// File: rtl/key_change_reporter.sv
module key_change_reporter #(
  parameter int SLOTS = 8,
  parameter int ROW_W = 4,
  parameter int COL_W = 3,
  localparam int RAW_W   = ROW_W + COL_W,
  localparam int ENTRY_W = RAW_W + 1,
  localparam int SC_W    = RAW_W + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     snap_valid,
  output logic                     snap_ready,
  input  logic [SLOTS*ENTRY_W-1:0] snap_entries,
  input  logic                     fn_layer_en,
  input  logic                     ghost_en,
  input  logic [RAW_W-1:0]         fn_code,
  output logic                     ev_valid,
  input  logic                     ev_ready,
  output logic                     ev_press,
  output logic [SC_W-1:0]          ev_code,
  output logic                     ev_sync
);
  import kcr_pkg::*;

  localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(SLOTS - 1);

  logic [SLOTS-1:0] dec_vld;
  logic [SC_W-1:0]  dec_code [SLOTS];
  logic             dec_ghost;

  kcr_decode #(.SLOTS(SLOTS), .ROW_W(ROW_W), .COL_W(COL_W)) u_decode (
    .entries     (snap_entries),
    .fn_layer_en (fn_layer_en),
    .ghost_en    (ghost_en),
    .fn_code     (fn_code),
    .key_vld     (dec_vld),
    .key_code    (dec_code),
    .ghost       (dec_ghost)
  );

  kcr_state_e       state;
  logic [IDX_W-1:0] idx;
  logic [SLOTS-1:0] cand_vld;
  logic [SC_W-1:0]  cand_code [SLOTS];
  logic [SLOTS-1:0] held_vld;
  logic [SC_W-1:0]  held_code [SLOTS];
  logic [SLOTS-1:0] gone;

  kcr_set_diff #(.SLOTS(SLOTS), .SC_W(SC_W)) u_diff (
    .old_vld  (held_vld),
    .old_code (held_code),
    .new_vld  (cand_vld),
    .new_code (cand_code),
    .gone     (gone)
  );

  logic step;
  logic at_last;
  assign step    = !ev_valid || ev_ready;
  assign at_last = (idx == IDX_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      idx        <= '0;
      cand_vld   <= '0;
      held_vld   <= '0;
      snap_ready <= 1'b1;
      ev_valid   <= 1'b0;
      ev_press   <= KIND_RELEASE;
      ev_code    <= '0;
      ev_sync    <= 1'b0;
      for (int k = 0; k < SLOTS; k++) begin
        cand_code[k] <= '0;
        held_code[k] <= '0;
      end
    end else begin
      ev_sync <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (snap_valid && !dec_ghost) begin
            cand_vld   <= dec_vld;
            cand_code  <= dec_code;
            idx        <= '0;
            snap_ready <= 1'b0;
            state      <= ST_REL;
          end
        end
        ST_REL: begin
          if (step) begin
            ev_valid <= gone[idx];
            ev_press <= KIND_RELEASE;
            ev_code  <= held_code[idx];
            if (at_last) begin
              idx   <= '0;
              state <= ST_PRS;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        ST_PRS: begin
          if (step) begin
            ev_valid <= cand_vld[idx];
            ev_press <= KIND_PRESS;
            ev_code  <= cand_code[idx];
            if (at_last) begin
              state <= ST_END;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        ST_END: begin
          if (step) begin
            ev_valid   <= 1'b0;
            ev_sync    <= 1'b1;
            held_vld   <= cand_vld;
            held_code  <= cand_code;
            snap_ready <= 1'b1;
            state      <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/kcr_checker.sv
module kcr_checker #(
  parameter int SC_W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            snap_valid,
  input logic            snap_ready,
  input logic            ev_valid,
  input logic            ev_ready,
  input logic            ev_press,
  input logic [SC_W-1:0] ev_code,
  input logic            ev_sync,
  input logic            dec_ghost
);
  // R10
  hold_payload_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && !ev_ready) |=> (ev_valid && $stable(ev_code) && $stable(ev_press)));

  // R9
  busy_no_ready_chk: assert property (@(posedge clk) disable iff (rst)
    ev_valid |-> !snap_ready);

  // R9
  ready_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(snap_ready) |-> $past(snap_valid));

  // R8
  sync_single_chk: assert property (@(posedge clk) disable iff (rst)
    ev_sync |=> !ev_sync);

  // R8
  sync_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ev_sync |-> !ev_valid);

  // R5
  rel_before_prs_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && ev_ready && ev_press) |=> !(ev_valid && !ev_press));

  // R4
  ghost_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (snap_valid && snap_ready && dec_ghost) |=> (snap_ready && !ev_valid && !ev_sync));
endmodule

bind key_change_reporter kcr_checker #(.SC_W(SC_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .snap_valid (snap_valid),
  .snap_ready (snap_ready),
  .ev_valid   (ev_valid),
  .ev_ready   (ev_ready),
  .ev_press   (ev_press),
  .ev_code    (ev_code),
  .ev_sync    (ev_sync),
  .dec_ghost  (dec_ghost)
);

// File: tb/sim_key_change_reporter.sv
module sim_key_change_reporter;
  localparam int SLOTS = 8;
  localparam int NEV   = 2 * SLOTS;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        snap_valid = 1'b0;
  logic        snap_ready;
  logic [63:0] snap_entries = '0;
  logic        fn_layer_en = 1'b0;
  logic        ghost_en = 1'b0;
  logic [6:0]  fn_code = 7'd7;
  logic        ev_valid;
  logic        ev_ready = 1'b0;
  logic        ev_press;
  logic [7:0]  ev_code;
  logic        ev_sync;

  always #10 clk = ~clk;

  key_change_reporter u0 (
    .clk(clk), .rst(rst), .snap_valid(snap_valid), .snap_ready(snap_ready),
    .snap_entries(snap_entries), .fn_layer_en(fn_layer_en), .ghost_en(ghost_en),
    .fn_code(fn_code), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_press(ev_press), .ev_code(ev_code), .ev_sync(ev_sync)
  );

  int checks = 0;
  int errors = 0;

  logic       mdl_vld [SLOTS];
  logic [7:0] mdl_code [SLOTS];
  logic       exp_kind [NEV];
  logic [7:0] exp_code [NEV];
  int         n_exp;
  bit         exp_drop;
  logic       got_kind [NEV];
  logic [7:0] got_code [NEV];
  int         n_got;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mk(bit v, int row, int col);
    return {v, 4'(row), 3'(col)};
  endfunction

  task automatic model(input logic [63:0] ent, input bit fnen, input bit ghen);
    bit         nv [SLOTS];
    logic [7:0] nc [SLOTS];
    logic [6:0] rw [SLOTS];
    bit fn_hit = 0, rs = 0, cs = 0, found;
    int cnt = 0;
    for (int k = 0; k < SLOTS; k++) begin
      rw[k] = ent[8*k +: 7];
      if (ent[8*k+7] && fnen && rw[k] == fn_code) fn_hit = 1;
    end
    for (int k = 0; k < SLOTS; k++) begin
      nv[k] = ent[8*k+7] && !(fnen && rw[k] == fn_code);
      nc[k] = {1'b0, rw[k]} + (fn_hit ? 8'd128 : 8'd0);
      if (nv[k]) cnt++;
    end
    for (int i = 0; i < SLOTS; i++)
      for (int j = i + 1; j < SLOTS; j++)
        if (nv[i] && nv[j]) begin
          if (rw[i][6:3] == rw[j][6:3]) rs = 1;
          if (rw[i][2:0] == rw[j][2:0]) cs = 1;
        end
    exp_drop = ghen && cnt >= 3 && rs && cs;
    n_exp = 0;
    if (exp_drop) return;
    for (int j = 0; j < SLOTS; j++) begin
      if (mdl_vld[j]) begin
        found = 0;
        for (int k = 0; k < SLOTS; k++) if (nv[k] && nc[k] == mdl_code[j]) found = 1;
        if (!found) begin
          exp_kind[n_exp] = 1'b0; exp_code[n_exp] = mdl_code[j]; n_exp++;
        end
      end
    end
    for (int k = 0; k < SLOTS; k++) begin
      if (nv[k]) begin
        exp_kind[n_exp] = 1'b1; exp_code[n_exp] = nc[k]; n_exp++;
      end
    end
    for (int k = 0; k < SLOTS; k++) begin
      mdl_vld[k] = nv[k]; mdl_code[k] = nc[k];
    end
  endtask

  task automatic run_snap(input logic [63:0] ent, input bit fnen, input bit ghen,
                          input int rdy_pct, input string tag);
    bit   hold, seen_sync, r, ready_low;
    logic [7:0] h_code;
    logic h_kind;
    model(ent, fnen, ghen);
    @(negedge clk);
    while (!snap_ready) @(negedge clk);
    snap_entries = ent; fn_layer_en = fnen; ghost_en = ghen; snap_valid = 1'b1;
    @(negedge clk);
    snap_valid = 1'b0;
    n_got = 0;
    if (exp_drop) begin
      ready_low = 0;
      for (int c = 0; c < NEV + 4; c++) begin
        ev_ready = 1'b1;
        if (ev_valid || ev_sync || !snap_ready) ready_low = 1;
        @(negedge clk);
      end
      check(!ready_low, "R4", {tag, " dropped snapshot stayed quiet"}, ready_low, 0);
      return;
    end
    hold = 0; seen_sync = 0; ready_low = 1;
    for (int c = 0; c < 2000 && !seen_sync; c++) begin
      if (hold)
        check(ev_valid && ev_code == h_code && ev_press == h_kind, "R10",
              {tag, " stalled payload held"}, ev_code, h_code);
      if (ev_sync) begin
        seen_sync = 1;
        check(!ev_valid, "R8", {tag, " valid low with sync"}, ev_valid, 0);
      end else begin
        if (snap_ready) ready_low = 0;
        r = ($urandom % 100) < rdy_pct;
        ev_ready = r;
        hold = ev_valid && !r;
        h_code = ev_code; h_kind = ev_press;
        if (ev_valid && r && n_got < NEV) begin
          got_kind[n_got] = ev_press; got_code[n_got] = ev_code; n_got++;
        end
        @(negedge clk);
      end
    end
    check(seen_sync, "R8", {tag, " sync pulse seen"}, seen_sync, 1);
    check(ready_low, "R9", {tag, " ready low while busy"}, ready_low, 1);
    @(negedge clk);
    check(!ev_sync, "R8", {tag, " sync lasts one cycle"}, ev_sync, 0);
    check(n_got == n_exp, "R6", {tag, " event count"}, n_got, n_exp);
    for (int i = 0; i < n_exp && i < n_got; i++) begin
      check(got_kind[i] == exp_kind[i], exp_kind[i] ? "R6" : "R5",
            {tag, " event kind"}, got_kind[i], exp_kind[i]);
      check(got_code[i] == exp_code[i], exp_kind[i] ? "R6" : "R5",
            {tag, " event code"}, got_code[i], exp_code[i]);
    end
  endtask

  initial begin
    #(20ns * 150000);
    errors++;
    $display("FAIL R8 watchdog: sync reached actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] e;
    void'($urandom(32'd4242));
    for (int k = 0; k < SLOTS; k++) begin mdl_vld[k] = 0; mdl_code[k] = '0; end
    repeat (3) @(negedge clk);
    check(snap_ready == 1'b1, "R11", "ready in reset", snap_ready, 1);
    check(ev_valid == 1'b0, "R11", "valid in reset", ev_valid, 0);
    check(ev_sync == 1'b0, "R11", "sync in reset", ev_sync, 0);
    rst = 1'b0;

    // R11: empty stored set after reset, no releases
    run_snap(64'd0, 0, 0, 100, "after reset");
    check(n_got == 0, "R11", "events from empty store", n_got, 0);

    // R1: row 2 col 5 in slot 3 gives scancode 21
    e = '0; e[31:24] = mk(1, 2, 5);
    run_snap(e, 0, 0, 100, "single key");
    check(n_got == 1 && got_code[0] == 8'd21, "R1", "scancode row2 col5", got_code[0], 21);

    // R2: unpressed slot with nonzero bits ignored
    e = '0; e[7:0] = mk(1, 2, 5); e[15:8] = mk(0, 9, 6);
    run_snap(e, 0, 0, 60, "unpressed slot");
    check(n_got == 1, "R2", "only the pressed key reported", n_got, 1);

    // R3: function key (row0 col7) swallowed, other key moved to layer 1
    e = '0; e[7:0] = mk(1, 0, 7); e[15:8] = mk(1, 1, 1);
    run_snap(e, 1, 0, 100, "fn layer");
    check(n_got == 2 && got_code[1] == 8'd137, "R3", "layer-1 scancode", got_code[1], 137);

    // R4: ghost pattern dropped, store untouched
    e = '0; e[7:0] = mk(1, 1, 1); e[15:8] = mk(1, 1, 2); e[23:16] = mk(1, 2, 1);
    run_snap(e, 0, 1, 100, "ghost");
    run_snap(64'd0, 0, 1, 100, "after ghost");
    check(n_got == 1 && got_code[0] == 8'd137, "R4", "store kept over dropped snapshot",
          got_code[0], 137);

    // R4: same pattern with filter off is kept
    run_snap(e, 0, 0, 100, "ghost filter off");
    check(n_got == 3, "R4", "pattern kept with filter off", n_got, 3);

    // R7: empty snapshot releases everything
    run_snap(64'd0, 0, 0, 50, "empty");
    check(n_got == 3 && got_kind[0] == 1'b0, "R7", "all released", n_got, 3);
    run_snap(64'd0, 0, 0, 100, "empty twice");
    check(n_got == 0, "R7", "store cleared", n_got, 0);

    for (int t = 0; t < 250; t++) begin
      e = '0;
      for (int k = 0; k < SLOTS; k++)
        e[8*k +: 8] = mk(($urandom % 100) < 45, $urandom % 4, 4 + ($urandom % 4));
      if (($urandom % 4) == 0) e[8*($urandom % SLOTS) +: 8] = mk(1, 0, 7);
      run_snap(e, $urandom % 2, $urandom % 2, 30 + ($urandom % 71), "random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule